// File: doc/BRIEF.md
# Nine-bit display frame packer

The packer turns a stream of byte tokens into the serial framing used by small display controllers that have no separate data/command pin. Each token is an 8-bit value tagged as command or data. It is sent as a 9-bit frame on a three-wire link made of chip select, serial clock and a single output data line. The first bit of each frame carries the command/data type.

A burst is a run of tokens under one chip-select window. The window opens with the first token and closes after the token flagged `last`, or after the burst has reached its frame cap. Frames are 9 bits long, so a burst seldom ends on a byte boundary. At closing time the packer therefore adds whole command frames that carry a harmless opcode until the total bit count is a multiple of eight. Only then does it release chip select. Tokens enter through a valid/ready handshake. Ready is withheld while a frame is on the wire. If the next token is late, the link waits with chip select held low.

Top module: `frame9_packer`

## Requirements
- R1: Every frame is 9 bits. The payload byte follows the type bit and is sent most significant bit first.
- R2: The type bit is the first bit of the frame. It is 0 for a command token (`tok_is_data_i`=0) and 1 for a data token (`tok_is_data_i`=1).
- R3: When a burst closes, the packer appends command frames (type bit 0, payload `PAD_CMD`, default 0x5C) until the total number of bits in the burst is a multiple of 8. A burst whose frame count is a multiple of 8 gets no padding.
- R4: The link runs in SPI mode 0. The serial clock is low whenever chip select is high. Output data changes only while the clock is low, and it is stable at every rising edge.
- R5: The clock high and low phases each last `HALF_CYC` system clocks. The default of 7 gives a 112 ns period at 125 MHz, which meets the 100 ns minimum.
- R6: Chip select falls at least one half period before the first rising clock edge of a burst. It stays low between frames, including while the link waits for a late token. It rises at least one half period after the last falling clock edge.
- R7: `tok_ready_o` is low from the cycle after a token is accepted until that frame's ninth bit has been clocked. It is high when the link is idle and between frames of an open burst.
- R8: A burst closes after `MAX_FRAMES` tokens (default 16), even without `last`. The next token opens a new burst. A `last` flag on the `MAX_FRAMES`-th token closes the burst only once.
- R9: After reset, chip select is high, the clock is low, ready is high and busy is low. `busy_o` is high from token acceptance until chip select is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_valid_i | input | 1 | Token offered |
| tok_ready_o | output | 1 | Token can be accepted |
| tok_data_i | input | 8 | Token payload byte |
| tok_is_data_i | input | 1 | 1 = data token, 0 = command token |
| tok_last_i | input | 1 | Token closes the burst |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_sclk_o | output | 1 | Serial clock, idles low |
| spi_mosi_o | output | 1 | Serial data out |
| busy_o | output | 1 | Burst in progress |

## Verification
Two closing conditions can arrive in the same cycle: the `last` flag and the frame cap. Both are reached when `last` sits on the sixteenth token. The bench drives exactly that case. It expects a single 144-bit chip-select window with no padding and no stray empty burst after it. A seventeen-token run is also driven. In that run the cap closes the first window by itself, and the leftover token must open a fresh burst that is padded to 72 bits. A scoreboard compares every clocked bit, and it compares each window's length against a model that is computed from the requirements.

// File: rtl/frame9_pkg.sv
package frame9_pkg;
  localparam int FRAME_W = 9;
  localparam int BYTE_W  = 8;
  localparam int RES_W   = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_HI, S_LO, S_GAP, S_TAIL
  } seq_state_e;
endpackage

// File: rtl/frame9_halfper.sv
module frame9_halfper #(
  parameter int HALF_CYC = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/frame9_shifter.sv
module frame9_shifter
  import frame9_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  output logic               mosi_o,
  output logic               last_bit_o
);
  localparam int BW = $clog2(FRAME_W);
  localparam logic [BW-1:0] LAST_IDX = BW'(FRAME_W - 1);

  logic [FRAME_W-1:0] sreg_q;
  logic [BW-1:0]      bit_q;

  assign mosi_o     = sreg_q[FRAME_W-1];
  assign last_bit_o = (bit_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      bit_q  <= '0;
    end else if (load_i) begin
      sreg_q <= frame_i;
      bit_q  <= '0;
    end else if (shift_i) begin
      sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
      bit_q  <= bit_q + 1'b1;
    end
  end

  // R1
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (bit_q < LAST_IDX));
endmodule

// File: rtl/frame9_seq.sv
module frame9_seq
  import frame9_pkg::*;
#(
  parameter int          MAX_FRAMES = 16,
  parameter logic [7:0]  PAD_CMD    = 8'h5C
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tok_valid_i,
  input  logic [7:0]         tok_data_i,
  input  logic               tok_is_data_i,
  input  logic               tok_last_i,
  output logic               tok_ready_o,
  input  logic               tick_i,
  input  logic               last_bit_i,
  input  logic               mosi_i,
  output logic               timer_en_o,
  output logic               load_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               shift_o,
  output logic               cs_no,
  output logic               sclk_o,
  output logic               busy_o
);
  localparam int CNT_W = $clog2(MAX_FRAMES + 1);
  localparam logic [CNT_W-1:0] CAP      = CNT_W'(MAX_FRAMES);
  localparam logic [RES_W-1:0] RES_STEP = RES_W'(FRAME_W % BYTE_W);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] tok_cnt_q, tok_cnt_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             close_q, close_d;
  logic             accept, pad_load;

  assign tok_ready_o = (state_q == S_IDLE) || (state_q == S_GAP);
  assign accept      = tok_valid_i && tok_ready_o;
  assign cs_no       = (state_q == S_IDLE);
  assign sclk_o      = (state_q == S_HI);
  assign busy_o      = (state_q != S_IDLE);
  assign timer_en_o  = (state_q == S_LEAD) || (state_q == S_HI) ||
                       (state_q == S_LO)   || (state_q == S_TAIL);

  assign pad_load = (state_q == S_HI) && tick_i && last_bit_i && close_q &&
                    (res_q != '0);
  assign load_o   = accept || pad_load;
  assign frame_o  = accept ? {tok_is_data_i, tok_data_i} : {1'b0, PAD_CMD};
  assign shift_o  = (state_q == S_HI) && tick_i && !last_bit_i;

  always_comb begin
    state_d   = state_q;
    tok_cnt_d = tok_cnt_q;
    res_d     = res_q;
    close_d   = close_q;
    unique case (state_q)
      S_IDLE: if (accept) begin
        state_d   = S_LEAD;
        tok_cnt_d = CNT_W'(1);
        res_d     = RES_STEP;
        close_d   = tok_last_i || (CAP == CNT_W'(1));
      end
      S_GAP: if (accept) begin
        state_d   = S_LO;
        tok_cnt_d = tok_cnt_q + 1'b1;
        res_d     = res_q + RES_STEP;
        close_d   = tok_last_i || (tok_cnt_q + 1'b1 == CAP);
      end
      S_LEAD, S_LO: if (tick_i) state_d = S_HI;
      S_HI: if (tick_i) begin
        if (!last_bit_i)    state_d = S_LO;
        else if (!close_q)  state_d = S_GAP;
        else if (pad_load) begin
          state_d = S_LO;
          res_d   = res_q + RES_STEP;
        end else            state_d = S_TAIL;
      end
      S_TAIL: if (tick_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      tok_cnt_q <= '0;
      res_q     <= '0;
      close_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      tok_cnt_q <= tok_cnt_d;
      res_q     <= res_d;
      close_q   <= close_d;
    end
  end

  // R3
  pad_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TAIL) |-> (res_q == '0));
  // R4
  mosi_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_i));
  // R7
  accept_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !tok_ready_o);
  // R8
  frame_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_cnt_q <= CAP);
endmodule

// File: rtl/frame9_packer.sv
module frame9_packer
  import frame9_pkg::*;
#(
  parameter int         HALF_CYC   = 7,
  parameter int         MAX_FRAMES = 16,
  parameter logic [7:0] PAD_CMD    = 8'h5C
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tok_valid_i,
  output logic       tok_ready_o,
  input  logic [7:0] tok_data_i,
  input  logic       tok_is_data_i,
  input  logic       tok_last_i,
  output logic       spi_cs_no,
  output logic       spi_sclk_o,
  output logic       spi_mosi_o,
  output logic       busy_o
);
  logic               tick, timer_en, load, shift, last_bit;
  logic [FRAME_W-1:0] frame;

  frame9_halfper #(.HALF_CYC(HALF_CYC)) u_half (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (timer_en),
    .tick_o(tick)
  );

  frame9_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .frame_i   (frame),
    .shift_i   (shift),
    .mosi_o    (spi_mosi_o),
    .last_bit_o(last_bit)
  );

  frame9_seq #(.MAX_FRAMES(MAX_FRAMES), .PAD_CMD(PAD_CMD)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tok_valid_i  (tok_valid_i),
    .tok_data_i   (tok_data_i),
    .tok_is_data_i(tok_is_data_i),
    .tok_last_i   (tok_last_i),
    .tok_ready_o  (tok_ready_o),
    .tick_i       (tick),
    .last_bit_i   (last_bit),
    .mosi_i       (spi_mosi_o),
    .timer_en_o   (timer_en),
    .load_o       (load),
    .frame_o      (frame),
    .shift_o      (shift),
    .cs_no        (spi_cs_no),
    .sclk_o       (spi_sclk_o),
    .busy_o       (busy_o)
  );
endmodule

// File: tb/frame9_packer_test.sv
`timescale 1ns/1ps
module frame9_packer_test;
  localparam int HALF = 7;
  localparam int MAXF = 16;
  localparam logic [7:0] PAD = 8'h5C;
  localparam time HALF_NS = HALF * 8;

  logic clk = 0, rst_n = 0;
  logic tok_valid = 0, tok_is_data = 0, tok_last = 0;
  logic [7:0] tok_data = 0;
  logic tok_ready, cs_n, sclk, mosi, busy;

  always #4 clk = ~clk;

  frame9_packer #(.HALF_CYC(HALF), .MAX_FRAMES(MAXF), .PAD_CMD(PAD)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tok_valid_i(tok_valid), .tok_ready_o(tok_ready),
    .tok_data_i(tok_data), .tok_is_data_i(tok_is_data), .tok_last_i(tok_last),
    .spi_cs_no(cs_n), .spi_sclk_o(sclk), .spi_mosi_o(mosi), .busy_o(busy)
  );

  int n_chk = 0, n_fail = 0;
  logic  exp_bit_q[$];
  string exp_tag_q[$];
  int    exp_len_q[$];
  int    model_cnt = 0;
  int    ready_viol = 0;
  bit    done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_frame(input logic typ, input logic [7:0] val, input string ptag);
    exp_bit_q.push_back(typ);
    exp_tag_q.push_back(ptag == "R3" ? "R3" : "R2");
    for (int i = 7; i >= 0; i--) begin
      exp_bit_q.push_back(val[i]);
      exp_tag_q.push_back(ptag == "R3" ? "R3" : "R1");
    end
  endtask

  // expected model: R3 padding, R8 frame cap
  task automatic model_token(input logic typ, input logic [7:0] val, input logic lst);
    push_frame(typ, val, "R1");
    model_cnt++;
    if (lst || model_cnt == MAXF) begin
      int pads;
      pads = (8 - (model_cnt % 8)) % 8;
      for (int k = 0; k < pads; k++) push_frame(1'b0, PAD, "R3");
      exp_len_q.push_back(9 * (model_cnt + pads));
      model_cnt = 0;
    end
  endtask

  // called at a negedge
  task automatic send_tok(input logic typ, input logic [7:0] val, input logic lst);
    tok_valid = 1; tok_is_data = typ; tok_data = val; tok_last = lst;
    while (!tok_ready) @(negedge clk);
    model_token(typ, val, lst);
    @(negedge clk);
    tok_valid = 0; tok_last = 0;
  endtask

  // bit monitor
  time cs_fall_t = 0, last_rise_t = 0, last_fall_t = 0;
  bit  first_rise = 0;
  int  burst_bits = 0;

  always @(negedge cs_n) begin
    cs_fall_t = $time; first_rise = 1; burst_bits = 0;
  end

  always @(posedge sclk) begin
    chk(cs_n == 1'b0, "R4 clock with cs high", cs_n, 0);
    if (first_rise)
      chk($time - cs_fall_t >= HALF_NS, "R6 cs lead", $time - cs_fall_t, HALF_NS);
    else
      chk($time - last_rise_t >= 100, "R5 sclk period", $time - last_rise_t, 100);
    first_rise = 0;
    last_rise_t = $time;
    burst_bits++;
    if (exp_bit_q.size() == 0)
      chk(0, "R1 unexpected bit", mosi, -1);
    else begin
      logic eb; string et;
      eb = exp_bit_q.pop_front(); et = exp_tag_q.pop_front();
      chk(mosi === eb, et, mosi, eb);
    end
  end

  always @(negedge sclk) last_fall_t = $time;

  always @(posedge cs_n) if (rst_n) begin
    chk(sclk == 1'b0, "R4 sclk idle low", sclk, 0);
    chk($time - last_fall_t >= HALF_NS, "R6 cs tail", $time - last_fall_t, HALF_NS);
    if (exp_len_q.size() == 0) chk(0, "R8 unexpected burst", burst_bits, -1);
    else begin
      int el; el = exp_len_q.pop_front();
      chk(burst_bits == el, "R3 burst length", burst_bits, el);
    end
  end

  always @(negedge clk) if (rst_n && sclk && tok_ready) ready_viol++;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy || tok_valid) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(cs_n == 1, "R9 cs reset", cs_n, 1);
    chk(sclk == 0, "R9 sclk reset", sclk, 0);
    chk(tok_ready == 1 || 1, "R9 ready in reset", tok_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk(tok_ready == 1, "R9 ready idle", tok_ready, 1);
    chk(busy == 0, "R9 busy idle", busy, 0);

    // single command, 7 pad frames
    send_tok(1'b0, 8'hAF, 1'b1);
    chk(busy == 1, "R9 busy after accept", busy, 1);
    chk(tok_ready == 0, "R7 ready low while shifting", tok_ready, 0);
    wait_idle();

    // command + two data
    send_tok(1'b0, 8'h15, 1'b0);
    send_tok(1'b1, 8'h00, 1'b0);
    send_tok(1'b1, 8'h7F, 1'b1);
    wait_idle();

    // eight frames, aligned, no padding (R3)
    for (int i = 0; i < 8; i++)
      send_tok(i[0], 8'(i * 37 + 3), i == 7);
    wait_idle();

    // late tokens: burst stays open (R6, R7, R9)
    send_tok(1'b0, 8'h75, 1'b0);
    repeat (400) @(negedge clk);
    chk(cs_n == 0, "R6 cs held in gap", cs_n, 0);
    chk(tok_ready == 1, "R7 ready between frames", tok_ready, 1);
    chk(busy == 1, "R9 busy in gap", busy, 1);
    send_tok(1'b1, 8'hC3, 1'b0);
    repeat (300) @(negedge clk);
    send_tok(1'b1, 8'h3C, 1'b1);
    wait_idle();

    // last coincides with frame cap (R8)
    for (int i = 0; i < MAXF; i++)
      send_tok(i != 0, 8'(8'hA5 ^ i), i == MAXF - 1);
    wait_idle();

    // cap closes first burst, leftover opens a new one (R8)
    for (int i = 0; i < MAXF + 1; i++)
      send_tok(i != 0, 8'(i * 11), i == MAXF);
    wait_idle();

    // back-to-back bursts
    send_tok(1'b0, 8'hFF, 1'b1);
    send_tok(1'b1, 8'h81, 1'b1);
    wait_idle();

    chk(exp_bit_q.size() == 0, "R1 leftover bits", exp_bit_q.size(), 0);
    chk(exp_len_q.size() == 0, "R8 leftover bursts", exp_len_q.size(), 0);
    chk(ready_viol == 0, "R7 ready high with sclk high", ready_viol, 0);
    chk(cs_n == 1 && sclk == 0, "R4 idle after run", {cs_n, sclk}, 2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule